// File: doc/BRIEF.md
# Coarse-Grain Thread Switch Controller

This block sequences a processor pipeline among a small set of register-resident thread contexts. Three user contexts and one context kept for trap and message handling each hold a bank of general-purpose registers, a program counter, a next-program counter and a processor-state word. A context pointer names the context whose registers the pipeline reads and writes. One thread runs until it hits a long-latency event: a remote memory miss or a failed synchronisation. The controller then parks that thread as suspended, drains the pipeline for a fixed number of cycles, and resumes another context that is already loaded.

New threads wait as start addresses in a small ready queue until a user context is free. A suspended thread becomes loaded again when its memory acknowledgement arrives. The pipeline, cache and network are outside the block. They appear only as a stall request, an acknowledgement carrying a context number, trap request and trap completion pulses, and a thread-exit pulse.

Top module: `ctx_switch_ctrl`

## Requirements
- R1: After reset every context is free, `issue_ok` is 0, `idle` is 1, `spawn_ready` is 1, and all registers read 0.
- R2: `ctx_state` holds a 2-bit field per context at bits [2i+1:2i], coded free=0, loaded=1, active=2, suspended=3. At most one context is active, and `issue_ok` is 1 only while the context at `ctx_ptr` is active.
- R3: A spawn is taken while `spawn_ready` is 1, that is, while fewer than RQ_DEPTH start addresses wait. On an edge where the queue holds an entry and a user context is free, the oldest entry loads into the lowest-numbered free user context, with PC=start, next-PC=start+4 and state word 0.
- R4: From idle, a loaded user context is dispatched at the next edge with no flush. `ctx_ptr` then names it, it becomes active, and `issue_ok` rises.
- R5: On each issuing cycle with no event, PC takes next-PC, and next-PC takes `br_target` when `br_taken` is set, otherwise next-PC+4. `psr_we` writes the state word of the active context.
- R6: `stall_req` in a user context marks that context suspended and leaves its PC unchanged. `issue_ok` is then 0 for exactly FLUSH_CYCLES cycles before the next context runs.
- R7: At the end of a flush, the next user context is the first loaded one in the order following the last dispatched user context, wrapping round. If none is loaded the block goes idle, and it dispatches from idle as soon as one becomes loaded.
- R8: `ack_valid` with `ack_ctx` naming a suspended user context makes that context loaded at the next edge. An acknowledgement for a context in any other state changes nothing.
- R9: `trap_req` from a running user context leaves that context loaded and, after a flush, runs context 3 from PC=TRAP_VEC. From idle it does so at the next edge. During a flush it redirects that flush to context 3.
- R10: While context 3 runs, `stall_req`, `thr_exit` and `trap_req` are ignored. `trap_done` frees context 3 and starts a flush that ends with round-robin selection.
- R11: `thr_exit` frees the active user context and starts a flush. The freed context can then take a thread from the ready queue.
- R12: Register writes go only to the context at `ctx_ptr` while `issue_ok` is 1. Reads return the register of the context at `ctx_ptr`, and other contexts keep their contents.
- R13: When several events arrive in one cycle from a user context, `trap_req` wins over `stall_req`, which wins over `thr_exit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_ok | output | 1 | Pipeline may issue from the active context |
| idle | output | 1 | No context is runnable |
| ctx_ptr | output | CTXW | Context pointer |
| ctx_state | output | 2*NCTX | Packed per-context thread state |
| cur_pc | output | XLEN | PC of the context at ctx_ptr |
| cur_npc | output | XLEN | Next-PC of the context at ctx_ptr |
| cur_psr | output | XLEN | State word of the context at ctx_ptr |
| br_taken | input | 1 | Issued instruction redirects next-PC |
| br_target | input | XLEN | Redirect address |
| psr_we | input | 1 | Write the state word of the active context |
| psr_wdata | input | XLEN | New state word |
| gpr_raddr | input | GAW | Register read index |
| gpr_rdata | output | XLEN | Register read data |
| gpr_we | input | 1 | Register write enable |
| gpr_waddr | input | GAW | Register write index |
| gpr_wdata | input | XLEN | Register write data |
| stall_req | input | 1 | Remote miss or failed synchronisation |
| ack_valid | input | 1 | Memory acknowledgement |
| ack_ctx | input | CTXW | Context the acknowledgement belongs to |
| trap_req | input | 1 | Trap or message request |
| trap_done | input | 1 | Trap handler finished |
| thr_exit | input | 1 | Active user thread terminates |
| spawn_valid | input | 1 | Offer a new thread start address |
| spawn_pc | input | XLEN | Start address of the new thread |
| spawn_ready | output | 1 | Ready queue has room |

## Verification
The properties take for granted that every input is sampled once per edge as a level. They also assume that an acknowledgement may name any context, including ones that are not suspended, and that event pulses may coincide in any combination. The stimulus drives all inputs only on the falling edge. It mixes directed sequences with a long random phase in which stalls, exits, traps, acknowledgements and spawns overlap freely, so the ignore and priority rules are exercised within those assumptions.

// File: rtl/csw_pkg.sv
// Shared types for the thread switch controller.
// Assumes: two-bit encodings are visible to neighbours through ctx_state.
package csw_pkg;
    typedef enum logic [1:0] {
        CS_FREE   = 2'd0,
        CS_LOADED = 2'd1,
        CS_ACTIVE = 2'd2,
        CS_SUSP   = 2'd3
    } ctx_st_e;

    typedef enum logic [1:0] {
        M_RUN   = 2'd0,
        M_FLUSH = 2'd1,
        M_IDLE  = 2'd2
    } mode_e;
endpackage

// File: rtl/csw_ready_fifo.sv
// Ready queue: holds start addresses of threads waiting for a free context.
// Assumes: the owner pops only when not empty; a push while full is dropped.
module csw_ready_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          do_push;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign head    = mem_q[rd_q];
    assign do_push = push && !full;

    // Advance pointers and occupancy on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (do_push) begin
                mem_q[wr_q] <= push_data;
                wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (pop) rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(pop);
        end
    end

    // R3: the owner never pops an empty queue.
    p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R3: a push offered while full leaves the occupancy unchanged unless popped.
    p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
endmodule

// File: rtl/csw_rr_pick.sv
// Round-robin picker: first set candidate after position 'last', wrapping.
// Assumes: last < N; purely combinational.
module csw_rr_pick #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] last,
    output logic [IW-1:0] pick,
    output logic          valid
);
    int idx;

    // Scan from farthest to nearest so the nearest candidate wins.
    always_comb begin
        pick  = '0;
        valid = 1'b0;
        idx   = 0;
        for (int k = N; k >= 1; k--) begin
            idx = (int'(last) + k) % N;
            if (cand[idx]) begin
                pick  = IW'(idx);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/csw_ctx_regs.sv
// Context register storage: per-context GPR bank, PC, next-PC, state word.
// Assumes: load, trap entry and advance never target the same context in
// one cycle; the controller guarantees this from the thread states.
module csw_ctx_regs #(
    parameter int XLEN     = 32,
    parameter int NUM_GPR  = 32,
    parameter int NCTX     = 4,
    parameter int TRAP_CTX = 3,
    parameter int TRAP_VEC = 'h80,
    localparam int CTXW    = $clog2(NCTX),
    localparam int GAW     = $clog2(NUM_GPR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CTXW-1:0] ptr,
    input  logic            advance,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_target,
    input  logic            psr_we,
    input  logic [XLEN-1:0] psr_wdata,
    input  logic            gpr_we,
    input  logic [GAW-1:0]  gpr_waddr,
    input  logic [XLEN-1:0] gpr_wdata,
    input  logic [GAW-1:0]  gpr_raddr,
    output logic [XLEN-1:0] gpr_rdata,
    input  logic            load_en,
    input  logic [CTXW-1:0] load_ctx,
    input  logic [XLEN-1:0] load_pc,
    input  logic            trap_enter,
    output logic [XLEN-1:0] cur_pc,
    output logic [XLEN-1:0] cur_npc,
    output logic [XLEN-1:0] cur_psr
);
    logic [XLEN-1:0] gpr_q [NCTX][NUM_GPR];
    logic [XLEN-1:0] pc_q  [NCTX];
    logic [XLEN-1:0] npc_q [NCTX];
    logic [XLEN-1:0] psr_q [NCTX];

    assign cur_pc    = pc_q[ptr];
    assign cur_npc   = npc_q[ptr];
    assign cur_psr   = psr_q[ptr];
    assign gpr_rdata = gpr_q[ptr][gpr_raddr];

    // Update the control words of each context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCTX; c++) begin
                pc_q[c]  <= '0;
                npc_q[c] <= '0;
                psr_q[c] <= '0;
            end
        end else begin
            for (int c = 0; c < NCTX; c++) begin
                if (load_en && load_ctx == CTXW'(c)) begin
                    pc_q[c]  <= load_pc;
                    npc_q[c] <= load_pc + XLEN'(4);
                    psr_q[c] <= '0;
                end else if (trap_enter && c == TRAP_CTX) begin
                    pc_q[c]  <= XLEN'(TRAP_VEC);
                    npc_q[c] <= XLEN'(TRAP_VEC) + XLEN'(4);
                end else if (advance && ptr == CTXW'(c)) begin
                    pc_q[c]  <= npc_q[c];
                    npc_q[c] <= br_taken ? br_target : npc_q[c] + XLEN'(4);
                    if (psr_we) psr_q[c] <= psr_wdata;
                end
            end
        end
    end

    // Write the register bank of the context at the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCTX; c++)
                for (int r = 0; r < NUM_GPR; r++) gpr_q[c][r] <= '0;
        end else if (gpr_we) begin
            gpr_q[ptr][gpr_waddr] <= gpr_wdata;
        end
    end

    // R5: a plain advance moves the old next-PC into PC.
    p_seq_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !br_taken) |=> (cur_pc == $past(cur_npc)));
    // R5: a taken branch loads the target as next-PC.
    p_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && br_taken) |=> (cur_npc == $past(br_target)));
endmodule

// File: rtl/ctx_switch_ctrl.sv
// Coarse-grain thread switch controller. Runs one context until a stall,
// exit or trap event, flushes for FLUSH_CYCLES, then selects the next
// context (trap context first when pending, else round-robin among loaded
// user contexts). Assumes: inputs are synchronous levels sampled each edge.
module ctx_switch_ctrl #(
    parameter int XLEN         = 32,
    parameter int NUM_GPR      = 32,
    parameter int NUM_USER     = 3,
    parameter int RQ_DEPTH     = 4,
    parameter int FLUSH_CYCLES = 3,
    parameter int TRAP_VEC     = 'h80,
    localparam int NCTX        = NUM_USER + 1,
    localparam int CTXW        = $clog2(NCTX),
    localparam int GAW         = $clog2(NUM_GPR),
    localparam int TRAP_CTX    = NUM_USER,
    localparam int CNTW        = $clog2(FLUSH_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              issue_ok,
    output logic              idle,
    output logic [CTXW-1:0]   ctx_ptr,
    output logic [2*NCTX-1:0] ctx_state,
    output logic [XLEN-1:0]   cur_pc,
    output logic [XLEN-1:0]   cur_npc,
    output logic [XLEN-1:0]   cur_psr,
    input  logic              br_taken,
    input  logic [XLEN-1:0]   br_target,
    input  logic              psr_we,
    input  logic [XLEN-1:0]   psr_wdata,
    input  logic [GAW-1:0]    gpr_raddr,
    output logic [XLEN-1:0]   gpr_rdata,
    input  logic              gpr_we,
    input  logic [GAW-1:0]    gpr_waddr,
    input  logic [XLEN-1:0]   gpr_wdata,
    input  logic              stall_req,
    input  logic              ack_valid,
    input  logic [CTXW-1:0]   ack_ctx,
    input  logic              trap_req,
    input  logic              trap_done,
    input  logic              thr_exit,
    input  logic              spawn_valid,
    input  logic [XLEN-1:0]   spawn_pc,
    output logic              spawn_ready
);
    import csw_pkg::*;

    mode_e           mode_q;
    logic [CNTW-1:0] cnt_q;
    logic [CTXW-1:0] ptr_q, last_q;
    logic            tgt_q;
    ctx_st_e         st_q [NCTX];

    logic                run, in_trap, usr_trap, ev_stall, ev_exit, ev_tdone;
    logic                advance, flush_end, go_trap, go_user;
    logic [NUM_USER-1:0] loaded_vec;
    logic [NCTX-1:0]     act_vec;
    logic [CTXW-1:0]     rr_pick, free_ctx;
    logic                rr_valid, free_valid;
    logic                rq_empty, rq_full, rq_pop;
    logic [XLEN-1:0]     rq_head;

    // Decode the events of the current cycle with their priority.
    always_comb begin
        run      = (mode_q == M_RUN);
        in_trap  = (ptr_q == CTXW'(TRAP_CTX));
        usr_trap = run && !in_trap && trap_req;
        ev_stall = run && !in_trap && !trap_req && stall_req;
        ev_exit  = run && !in_trap && !trap_req && !stall_req && thr_exit;
        ev_tdone = run && in_trap && trap_done;
        advance  = run && !usr_trap && !ev_stall && !ev_exit && !ev_tdone;
        flush_end = (mode_q == M_FLUSH) && (cnt_q == '0);
        go_trap  = (flush_end && (tgt_q || trap_req)) ||
                   ((mode_q == M_IDLE) && trap_req);
        go_user  = rr_valid && !trap_req &&
                   ((flush_end && !tgt_q) || (mode_q == M_IDLE));
    end

    // Find the lowest-numbered free user context for the ready queue.
    always_comb begin
        free_ctx   = '0;
        free_valid = 1'b0;
        for (int i = NUM_USER - 1; i >= 0; i--) begin
            if (st_q[i] == CS_FREE) begin
                free_ctx   = CTXW'(i);
                free_valid = 1'b1;
            end
        end
    end

    assign rq_pop = !rq_empty && free_valid;

    // Pack per-context state for the port and the checks.
    for (genvar g = 0; g < NCTX; g++) begin : g_pack
        assign ctx_state[2*g +: 2] = st_q[g];
        assign act_vec[g]          = (st_q[g] == CS_ACTIVE);
        if (g < NUM_USER) begin : g_user
            assign loaded_vec[g] = (st_q[g] == CS_LOADED);
        end
    end

    csw_rr_pick #(.N(NUM_USER), .IW(CTXW)) u_pick (
        .cand  (loaded_vec),
        .last  (last_q),
        .pick  (rr_pick),
        .valid (rr_valid)
    );

    csw_ready_fifo #(.W(XLEN), .DEPTH(RQ_DEPTH)) u_rq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (spawn_valid),
        .push_data (spawn_pc),
        .pop       (rq_pop),
        .head      (rq_head),
        .empty     (rq_empty),
        .full      (rq_full)
    );

    csw_ctx_regs #(
        .XLEN(XLEN), .NUM_GPR(NUM_GPR), .NCTX(NCTX),
        .TRAP_CTX(TRAP_CTX), .TRAP_VEC(TRAP_VEC)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr        (ptr_q),
        .advance    (advance),
        .br_taken   (br_taken),
        .br_target  (br_target),
        .psr_we     (psr_we),
        .psr_wdata  (psr_wdata),
        .gpr_we     (gpr_we && run),
        .gpr_waddr  (gpr_waddr),
        .gpr_wdata  (gpr_wdata),
        .gpr_raddr  (gpr_raddr),
        .gpr_rdata  (gpr_rdata),
        .load_en    (rq_pop),
        .load_ctx   (free_ctx),
        .load_pc    (rq_head),
        .trap_enter (go_trap),
        .cur_pc     (cur_pc),
        .cur_npc    (cur_npc),
        .cur_psr    (cur_psr)
    );

    // Sequence thread states, flush timing and the context pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_IDLE;
            cnt_q  <= '0;
            ptr_q  <= '0;
            last_q <= CTXW'(NUM_USER - 1);
            tgt_q  <= 1'b0;
            for (int i = 0; i < NCTX; i++) st_q[i] <= CS_FREE;
        end else begin
            if (ack_valid && ack_ctx < CTXW'(NUM_USER) && st_q[ack_ctx] == CS_SUSP)
                st_q[ack_ctx] <= CS_LOADED;
            if (rq_pop) st_q[free_ctx] <= CS_LOADED;

            if (usr_trap || ev_stall || ev_exit || ev_tdone) begin
                mode_q <= M_FLUSH;
                cnt_q  <= CNTW'(FLUSH_CYCLES - 1);
                tgt_q  <= usr_trap;
                if (usr_trap)      st_q[ptr_q] <= CS_LOADED;
                else if (ev_stall) st_q[ptr_q] <= CS_SUSP;
                else               st_q[ptr_q] <= CS_FREE;
            end else if (mode_q == M_FLUSH && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if (trap_req) tgt_q <= 1'b1;
            end else if (go_trap) begin
                ptr_q  <= CTXW'(TRAP_CTX);
                st_q[TRAP_CTX] <= CS_ACTIVE;
                mode_q <= M_RUN;
                tgt_q  <= 1'b0;
            end else if (go_user) begin
                ptr_q  <= rr_pick;
                last_q <= rr_pick;
                st_q[rr_pick] <= CS_ACTIVE;
                mode_q <= M_RUN;
                tgt_q  <= 1'b0;
            end else if (flush_end) begin
                mode_q <= M_IDLE;
                tgt_q  <= 1'b0;
            end
        end
    end

    assign issue_ok    = (mode_q == M_RUN);
    assign idle        = (mode_q == M_IDLE);
    assign ctx_ptr     = ptr_q;
    assign spawn_ready = !rq_full;

    // R2: issue only from an active context, and at most one is active.
    p_issue_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |-> (st_q[ptr_q] == CS_ACTIVE));
    p_one_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act_vec) <= 1);
    // R6: a stall suspends the context and stops issue on the next cycle.
    p_stall_suspends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stall |=> (!issue_ok && st_q[$past(ptr_q)] == CS_SUSP));
    // R6: the flush continues while cycles remain.
    p_flush_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_FLUSH && cnt_q != '0) |=> (mode_q == M_FLUSH));
    // R8: an acknowledgement wakes a suspended user context.
    p_ack_wakes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_ctx < CTXW'(NUM_USER) && st_q[ack_ctx] == CS_SUSP)
        |=> (st_q[$past(ack_ctx)] == CS_LOADED));
    // R9: a trap from idle runs the trap context at the next edge.
    p_idle_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && trap_req) |=> (issue_ok && ctx_ptr == CTXW'(TRAP_CTX)));
    // R10: the trap context keeps running until trap_done.
    p_trap_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && ctx_ptr == CTXW'(TRAP_CTX) && !trap_done)
        |=> (issue_ok && ctx_ptr == CTXW'(TRAP_CTX)));
endmodule

// File: tb/sim_ctx_switch_ctrl.sv
module sim_ctx_switch_ctrl;
    localparam int F  = 3;
    localparam int TV = 'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        issue_ok, idle, spawn_ready;
    logic [1:0]  ctx_ptr;
    logic [7:0]  ctx_state;
    logic [31:0] cur_pc, cur_npc, cur_psr, gpr_rdata;
    logic        br_taken = 0, psr_we = 0, gpr_we = 0, stall_req = 0;
    logic        ack_valid = 0, trap_req = 0, trap_done = 0, thr_exit = 0, spawn_valid = 0;
    logic [31:0] br_target = 0, psr_wdata = 0, gpr_wdata = 0, spawn_pc = 0;
    logic [4:0]  gpr_raddr = 0, gpr_waddr = 0;
    logic [1:0]  ack_ctx = 0;

    ctx_switch_ctrl u0 (.*);

    int total = 0, fails = 0;
    bit finished = 0;
    string phase = "R1";

    // Behavioural reference state.
    int          st[4], n_st[4];
    int          mmode, mcnt, mptr, mlast, mtgt;
    logic [31:0] mpc[4], mnpc[4], mpsr[4];
    logic [31:0] mg[4][32];
    logic [31:0] rq[$];
    int          n_mode, n_cnt, n_ptr, n_last, n_tgt;
    logic [31:0] n_pc[4], n_npc[4], n_psr[4];

    task automatic check(string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    function automatic int rr_next();
        for (int k = 1; k <= 3; k++) if (st[(mlast + k) % 3] == 1) return (mlast + k) % 3;
        return -1;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            st[c] = 0; mpc[c] = 0; mnpc[c] = 0; mpsr[c] = 0;
            for (int r = 0; r < 32; r++) mg[c][r] = 0;
        end
        mmode = 2; mcnt = 0; mptr = 0; mlast = 2; mtgt = 0;
        rq.delete();
    endtask

    task automatic enter_trap();
        n_ptr = 3; n_st[3] = 2; n_mode = 0; n_tgt = 0;
        n_pc[3] = TV; n_npc[3] = TV + 4;
    endtask

    // Next state of the reference, from current state and driven inputs.
    task automatic model_next();
        int fr, p, sz;
        bit intr;
        n_st = st; n_mode = mmode; n_cnt = mcnt; n_ptr = mptr; n_last = mlast; n_tgt = mtgt;
        n_pc = mpc; n_npc = mnpc; n_psr = mpsr;
        intr = (mptr == 3);
        if (ack_valid && ack_ctx < 3 && st[ack_ctx] == 3) n_st[ack_ctx] = 1;
        sz = rq.size();
        fr = -1;
        for (int c = 2; c >= 0; c--) if (st[c] == 0) fr = c;
        if (sz > 0 && fr >= 0) begin
            n_st[fr] = 1; n_pc[fr] = rq[0]; n_npc[fr] = rq[0] + 4; n_psr[fr] = 0;
            void'(rq.pop_front());
        end
        if (spawn_valid && sz < 4) rq.push_back(spawn_pc);
        p = rr_next();
        if (mmode == 0) begin
            if (gpr_we) mg[mptr][gpr_waddr] = gpr_wdata;
            if (!intr && trap_req) begin
                n_st[mptr] = 1; n_mode = 1; n_cnt = F - 1; n_tgt = 1;
            end else if (!intr && stall_req) begin
                n_st[mptr] = 3; n_mode = 1; n_cnt = F - 1; n_tgt = 0;
            end else if (!intr && thr_exit) begin
                n_st[mptr] = 0; n_mode = 1; n_cnt = F - 1; n_tgt = 0;
            end else if (intr && trap_done) begin
                n_st[3] = 0; n_mode = 1; n_cnt = F - 1; n_tgt = 0;
            end else begin
                n_pc[mptr] = mnpc[mptr];
                n_npc[mptr] = br_taken ? br_target : mnpc[mptr] + 4;
                if (psr_we) n_psr[mptr] = psr_wdata;
            end
        end else if (mmode == 1) begin
            if (mcnt != 0) begin
                n_cnt = mcnt - 1;
                if (trap_req) n_tgt = 1;
            end else if (mtgt || trap_req) enter_trap();
            else if (p >= 0) begin
                n_ptr = p; n_last = p; n_st[p] = 2; n_mode = 0; n_tgt = 0;
            end else begin
                n_mode = 2; n_tgt = 0;
            end
        end else begin
            if (trap_req) enter_trap();
            else if (p >= 0) begin
                n_ptr = p; n_last = p; n_st[p] = 2; n_mode = 0;
            end
        end
    endtask

    task automatic model_commit();
        st = n_st; mmode = n_mode; mcnt = n_cnt; mptr = n_ptr; mlast = n_last; mtgt = n_tgt;
        mpc = n_pc; mnpc = n_npc; mpsr = n_psr;
    endtask

    task automatic compare_all();
        logic [7:0] es;
        for (int c = 0; c < 4; c++) es[2*c +: 2] = st[c][1:0];
        check("R2 ctx_state", 64'(ctx_state), 64'(es));
        check("R6 issue_ok", 64'(issue_ok), 64'(mmode == 0));
        check("R7 idle", 64'(idle), 64'(mmode == 2));
        check("R7 ctx_ptr", 64'(ctx_ptr), 64'(mptr));
        check("R5 cur_pc", 64'(cur_pc), 64'(mpc[mptr]));
        check("R5 cur_npc", 64'(cur_npc), 64'(mnpc[mptr]));
        check("R5 cur_psr", 64'(cur_psr), 64'(mpsr[mptr]));
        check("R3 spawn_ready", 64'(spawn_ready), 64'(rq.size() < 4));
        check("R12 gpr_rdata", 64'(gpr_rdata), 64'(mg[mptr][gpr_raddr]));
    endtask

    task automatic tick();
        model_next();
        @(posedge clk);
        model_commit();
        @(negedge clk);
        compare_all();
        br_taken = 0; psr_we = 0; gpr_we = 0; stall_req = 0; ack_valid = 0;
        trap_req = 0; trap_done = 0; thr_exit = 0; spawn_valid = 0;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        total++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        phase = "R1";
        check("R1 ctx_state", 64'(ctx_state), 64'h0);
        check("R1 issue_ok", 64'(issue_ok), 64'h0);
        check("R1 idle", 64'(idle), 64'h1);
        check("R1 spawn_ready", 64'(spawn_ready), 64'h1);

        phase = "R3";
        spawn_valid = 1; spawn_pc = 32'h100; tick();
        tick();
        check("R3 ctx0 loaded", 64'(ctx_state[1:0]), 64'h1);
        phase = "R4";
        tick();
        check("R4 dispatch issue", 64'(issue_ok), 64'h1);
        check("R4 dispatch ptr", 64'(ctx_ptr), 64'h0);
        check("R4 start pc", 64'(cur_pc), 64'h100);

        phase = "R5";
        tick();
        br_taken = 1; br_target = 32'h200; tick();
        tick();
        check("R5 branch pc", 64'(cur_pc), 64'h200);
        check("R5 branch npc", 64'(cur_npc), 64'h204);

        phase = "R12";
        gpr_we = 1; gpr_waddr = 5; gpr_wdata = 32'hAAAA; gpr_raddr = 5; tick();
        check("R12 write read", 64'(gpr_rdata), 64'hAAAA);

        phase = "R6";
        spawn_valid = 1; spawn_pc = 32'h300; tick();
        tick();
        stall_req = 1; tick();
        check("R6 no issue", 64'(issue_ok), 64'h0);
        check("R6 suspended", 64'(ctx_state[1:0]), 64'h3);
        check("R6 pc held", 64'(cur_pc), 64'h20c);
        tick();
        check("R6 flush 2", 64'(issue_ok), 64'h0);
        tick();
        check("R6 flush 3", 64'(issue_ok), 64'h0);
        tick();
        check("R6 resume", 64'(issue_ok), 64'h1);
        check("R7 next ctx", 64'(ctx_ptr), 64'h1);
        check("R12 other bank", 64'(gpr_rdata), 64'h0);

        phase = "R8";
        ack_valid = 1; ack_ctx = 0; tick();
        check("R8 wake", 64'(ctx_state[1:0]), 64'h1);
        ack_valid = 1; ack_ctx = 2; tick();
        check("R8 ignored ack", 64'(ctx_state[5:4]), 64'h0);

        phase = "R9";
        trap_req = 1; tick();
        check("R9 interrupted loaded", 64'(ctx_state[3:2]), 64'h1);
        repeat (3) tick();
        check("R9 trap ptr", 64'(ctx_ptr), 64'h3);
        check("R9 trap pc", 64'(cur_pc), 64'(TV));

        phase = "R10";
        stall_req = 1; thr_exit = 1; tick();
        trap_req = 1; tick();
        check("R10 still trap", 64'(ctx_ptr), 64'h3);
        check("R10 still issue", 64'(issue_ok), 64'h1);
        trap_done = 1; tick();
        check("R10 trap freed", 64'(ctx_state[7:6]), 64'h0);
        repeat (3) tick();
        check("R10 rr after trap", 64'(ctx_ptr), 64'h0);

        phase = "R13";
        stall_req = 1; thr_exit = 1; tick();
        check("R13 stall over exit", 64'(ctx_state[1:0]), 64'h3);
        repeat (3) tick();
        check("R13 next", 64'(ctx_ptr), 64'h1);

        phase = "R11";
        thr_exit = 1; tick();
        check("R11 freed", 64'(ctx_state[3:2]), 64'h0);
        repeat (3) tick();
        check("R7 idle none", 64'(idle), 64'h1);
        spawn_valid = 1; spawn_pc = 32'h500; tick();
        tick();
        check("R11 reuse ctx1", 64'(ctx_state[3:2]), 64'h1);
        tick();
        check("R11 dispatched", 64'(ctx_ptr), 64'h1);

        phase = "R9";
        stall_req = 1; tick();
        trap_req = 1; tick();
        tick();
        tick();
        check("R9 redirected flush", 64'(ctx_ptr), 64'h3);

        phase = "R3";
        for (int i = 0; i < 6; i++) begin
            spawn_valid = 1; spawn_pc = 32'h1000 + 32'(i) * 16; tick();
        end

        phase = "R2";
        for (int i = 0; i < 4000; i++) begin
            stall_req   = ($urandom % 100) < 6;
            thr_exit    = ($urandom % 100) < 3;
            trap_req    = ($urandom % 100) < 3;
            trap_done   = ($urandom % 100) < 12;
            ack_valid   = ($urandom % 100) < 20;
            ack_ctx     = 2'($urandom);
            spawn_valid = ($urandom % 100) < 12;
            spawn_pc    = $urandom & 32'hFFFC;
            br_taken    = ($urandom % 100) < 20;
            br_target   = $urandom & 32'hFFFC;
            psr_we      = ($urandom % 100) < 10;
            psr_wdata   = $urandom;
            gpr_we      = ($urandom % 100) < 30;
            gpr_waddr   = 5'($urandom);
            gpr_wdata   = $urandom;
            gpr_raddr   = 5'($urandom);
            tick();
        end
        finish_run();
    end
endmodule